// File: doc/BRIEF.md
# Word Shifter with 64-bit Sign Extension

This block is the right-shift unit of a 64-bit datapath whose shift instructions operate on 32-bit words. It takes the low word of a 64-bit source operand, shifts it right by 0 to 31 places and widens the 32-bit outcome back to 64 bits by copying bit 31 of that outcome into the upper half. This widening happens for logical shifts as well as arithmetic ones. The shift amount comes either from a 5-bit immediate field or from the low five bits of a 64-bit count register. A two-bit operation code selects which source is used and which fill is applied.

A legal source operand is a sign-extended 32-bit value. When the upper 33 bits of the source (bit 31 and everything above it) disagree, the block raises a flag to mark the input as malformed. It still produces the value computed from the low word, so its behaviour stays deterministic. The result can be presented combinationally, or from an output register that adds one cycle of latency. A parameter chooses between the two.

Top module: `word_shifter`

## Requirements
- R1: The shifted value depends only on source bits 31..0; source bits 63..32 have no effect on `res_o`.
- R2: In arithmetic operations (op bit 0 = 1), the vacated upper positions of the 32-bit word take the value of source bit 31.
- R3: In logical operations (op bit 0 = 0), the vacated upper positions of the 32-bit word are filled with zeros.
- R4: In register-count operations (op bit 1 = 1), the amount is `cnt_reg_i[4:0]`, and bits 63..5 of the count register are ignored.
- R5: Operation codes are 00 logical/immediate, 01 arithmetic/immediate, 10 logical/register, 11 arithmetic/register. Immediate operations take their amount from `imm_cnt_i`, and the count register is ignored.
- R6: `res_o[63:32]` always equals 32 copies of `res_o[31]`, for both logical and arithmetic shifts.
- R7: `bad_src_o` is 1 exactly when source bits 63..31 are not all equal.
- R8: An amount of zero passes source bits 31..0 through unchanged, and the result is then sign-extended from bit 31.
- R9: While `bad_src_o` is 1, `res_o` still carries the value computed from the low source word.
- R10: With `REG_OUT`=1, results and the flag appear one clock after the inputs, and reset clears both to zero. With `REG_OUT`=0 they follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low reset of the output register |
| src_i | input | 64 | Source operand; the low word is shifted |
| imm_cnt_i | input | 5 | Immediate shift amount |
| cnt_reg_i | input | 64 | Count register; only bits 4..0 are used |
| op_i | input | 2 | Operation code: bit 0 arithmetic, bit 1 register count |
| res_o | output | 64 | Sign-extended shift result |
| bad_src_o | output | 1 | Source operand not properly sign-extended |

## Verification
The bench builds two instances with the default 64-bit datapath and 32-bit word. One instance has `REG_OUT`=1 and the other has `REG_OUT`=0, and both are driven by the same stimulus. The registered instance is the one that exposes the one-cycle latency and the cleared reset state to the scoreboard. The combinational instance lets every vector be compared within the cycle it is applied, so a fault in the shared shift path is reported twice, each time through a different timing path. A full sweep of all 32 amounts under all four operation codes covers every stage of the shifter in both its shift and pass positions.

// File: rtl/wsh_pkg.sv
package wsh_pkg;

    typedef enum logic [1:0] {
        SH_LOG_IMM = 2'b00,
        SH_ARI_IMM = 2'b01,
        SH_LOG_VAR = 2'b10,
        SH_ARI_VAR = 2'b11
    } shift_op_e;

    typedef struct packed {
        logic arith;
        logic use_reg;
    } op_dec_t;

    function automatic op_dec_t decode_op(shift_op_e op);
        op_dec_t d;
        unique case (op)
            SH_LOG_IMM: d = '{arith: 1'b0, use_reg: 1'b0};
            SH_ARI_IMM: d = '{arith: 1'b1, use_reg: 1'b0};
            SH_LOG_VAR: d = '{arith: 1'b0, use_reg: 1'b1};
            SH_ARI_VAR: d = '{arith: 1'b1, use_reg: 1'b1};
            default:    d = '{arith: 1'b0, use_reg: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/wsh_amt_sel.sv
module wsh_amt_sel #(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] imm_i,
    input  logic [CNT_W-1:0] reg_lo_i,
    input  logic             use_reg_i,
    output logic [CNT_W-1:0] amt_o
);

    always_comb begin
        if (use_reg_i) begin
            amt_o = reg_lo_i;
        end else begin
            amt_o = imm_i;
        end
    end

endmodule

// File: rtl/wsh_barrel.sv
module wsh_barrel #(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  amt_i,
    input  logic              fill_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] stg [CNT_W+1];

    assign stg[0] = word_i;

    for (genvar s = 0; s < CNT_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stg[s+1] = amt_i[s] ? {{SH{fill_i}}, stg[s][WORD_W-1:SH]} : stg[s];
    end

    assign word_o = stg[CNT_W];

endmodule

// File: rtl/wsh_sext_chk.sv
module wsh_sext_chk #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32,
    localparam int HI_W = DATA_W - WORD_W + 1
) (
    input  logic [HI_W-1:0]   src_hi_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [DATA_W-1:0] res_o,
    output logic              bad_o
);

    localparam int EXT_W = DATA_W - WORD_W;

    logic all_one;
    logic all_zero;

    assign all_one  = &src_hi_i;
    assign all_zero = ~|src_hi_i;
    assign bad_o    = ~(all_one | all_zero);
    assign res_o    = {{EXT_W{word_i[WORD_W-1]}}, word_i};

endmodule

// File: rtl/word_shifter.sv
module word_shifter
    import wsh_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int WORD_W  = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int CNT_W  = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] src_i,
    input  logic [CNT_W-1:0]  imm_cnt_i,
    input  logic [DATA_W-1:0] cnt_reg_i,
    input  logic [1:0]        op_i,
    output logic [DATA_W-1:0] res_o,
    output logic              bad_src_o
);

    op_dec_t           dec;
    logic [CNT_W-1:0]  amt;
    logic [WORD_W-1:0] low_word;
    logic [WORD_W-1:0] shifted;
    logic              fill;
    logic [DATA_W-1:0] comb_res;
    logic              comb_bad;
    logic              unused_cnt_hi;

    assign dec           = decode_op(shift_op_e'(op_i));
    assign low_word      = src_i[WORD_W-1:0];
    assign fill          = dec.arith & low_word[WORD_W-1];
    assign unused_cnt_hi = ^cnt_reg_i[DATA_W-1:CNT_W];

    wsh_amt_sel #(.CNT_W(CNT_W)) u_amt (
        .imm_i     (imm_cnt_i),
        .reg_lo_i  (cnt_reg_i[CNT_W-1:0]),
        .use_reg_i (dec.use_reg),
        .amt_o     (amt)
    );

    wsh_barrel #(.WORD_W(WORD_W)) u_shift (
        .word_i (low_word),
        .amt_i  (amt),
        .fill_i (fill),
        .word_o (shifted)
    );

    wsh_sext_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_sext (
        .src_hi_i (src_i[DATA_W-1:WORD_W-1]),
        .word_i   (shifted),
        .res_o    (comb_res),
        .bad_o    (comb_bad)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                res_o     <= '0;
                bad_src_o <= 1'b0;
            end else begin
                res_o     <= comb_res;
                bad_src_o <= comb_bad;
            end
        end
    end else begin : g_comb
        assign res_o     = comb_res;
        assign bad_src_o = comb_bad;
    end

endmodule

// File: rtl/wsh_checker.sv
module wsh_checker #(
    parameter int DATA_W  = 64,
    parameter int WORD_W  = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int CNT_W  = $clog2(WORD_W)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [DATA_W-1:0] src_i,
    input logic [CNT_W-1:0]  imm_cnt_i,
    input logic [DATA_W-1:0] cnt_reg_i,
    input logic [1:0]        op_i,
    input logic [DATA_W-1:0] comb_res_i,
    input logic              comb_bad_i,
    input logic [DATA_W-1:0] res_o,
    input logic              bad_src_o
);

    localparam int HI_W = DATA_W - WORD_W + 1;

    logic [CNT_W-1:0] eff;
    logic             uniform;
    logic             seen;

    always_comb begin
        eff = op_i[1] ? cnt_reg_i[CNT_W-1:0] : imm_cnt_i;
    end

    assign uniform = (src_i[DATA_W-1:WORD_W-1] == {HI_W{1'b0}}) ||
                     (src_i[DATA_W-1:WORD_W-1] == {HI_W{1'b1}});

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seen <= 1'b0;
        else         seen <= 1'b1;
    end

    AST_SIGN_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        comb_res_i[DATA_W-1:WORD_W] == {(DATA_W-WORD_W){comb_res_i[WORD_W-1]}}); // R6

    AST_LOGIC_ZERO_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!op_i[0] && eff != '0) |-> !comb_res_i[WORD_W-1]); // R3

    AST_ARITH_KEEPS_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i[0] |-> (comb_res_i[WORD_W-1] == src_i[WORD_W-1])); // R2

    AST_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eff == '0) |-> (comb_res_i[WORD_W-1:0] == src_i[WORD_W-1:0])); // R8

    AST_GOOD_SRC_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uniform |-> !comb_bad_i); // R7

    AST_BAD_SRC_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !uniform |-> comb_bad_i); // R7

    if (REG_OUT) begin : g_lat
        AST_REG_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            seen |-> (res_o == $past(comb_res_i) && bad_src_o == $past(comb_bad_i))); // R10
    end else begin : g_nolat
        AST_COMB_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (res_o == comb_res_i) && (bad_src_o == comb_bad_i)); // R10
    end

endmodule

bind word_shifter wsh_checker #(
    .DATA_W  (DATA_W),
    .WORD_W  (WORD_W),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .imm_cnt_i  (imm_cnt_i),
    .cnt_reg_i  (cnt_reg_i),
    .op_i       (op_i),
    .comb_res_i (comb_res),
    .comb_bad_i (comb_bad),
    .res_o      (res_o),
    .bad_src_o  (bad_src_o)
);

// File: tb/tb_word_shifter.sv
`timescale 1ns/1ps
module tb_word_shifter;

    typedef struct {
        logic [63:0] res;
        logic        bad;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic [4:0]  imm = '0;
    logic [63:0] creg = '0;
    logic [1:0]  op = '0;
    logic [63:0] res_r, res_c;
    logic        bad_r, bad_c;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    exp_t pend_q[$];
    exp_t ready_q[$];

    always #10 clk = ~clk;

    word_shifter #(.REG_OUT(1'b1)) dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .imm_cnt_i(imm),
        .cnt_reg_i(creg), .op_i(op), .res_o(res_r), .bad_src_o(bad_r)
    );

    word_shifter #(.REG_OUT(1'b0)) dut_comb (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .imm_cnt_i(imm),
        .cnt_reg_i(creg), .op_i(op), .res_o(res_c), .bad_src_o(bad_c)
    );

    task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [63:0] s, input logic [4:0] i,
                                   input logic [63:0] c, input logic [1:0] o, input string tag);
        exp_t e;
        logic [31:0] w;
        logic [31:0] r;
        int n;
        w = s[31:0];
        n = o[1] ? int'(c[4:0]) : int'(i);
        if (o[0]) r = 32'($signed(w) >>> n);
        else      r = w >> n;
        e.res = {{32{r[31]}}, r};
        e.bad = !((s[63:31] == 33'h0) || (s[63:31] == {33{1'b1}}));
        e.tag = tag;
        return e;
    endfunction

    task automatic apply(input logic [63:0] s, input logic [4:0] i, input logic [63:0] c,
                         input logic [1:0] o, input string tag);
        exp_t e;
        @(posedge clk);
        #2;
        src = s; imm = i; creg = c; op = o;
        e = model(s, i, c, o, tag);
        pend_q.push_back(e);
        #3;
        check((res_c == e.res) && (bad_c == e.bad), {tag, " comb"}, {bad_c, res_c}, {e.bad, e.res});
    endtask

    always @(posedge clk) begin
        if (pend_q.size() > 0) ready_q.push_back(pend_q.pop_front());
    end

    always @(negedge clk) begin
        if (rst_n && ready_q.size() > 0) begin
            exp_t e;
            e = ready_q.pop_front();
            check((res_r == e.res) && (bad_r == e.bad), {e.tag, " reg"}, {bad_r, res_r}, {e.bad, e.res});
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #4_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset clears registered result and flag
        check((res_r == 64'h0) && (bad_r == 1'b0), "R10 reset", {bad_r, res_r}, 65'h0);
        @(posedge clk); #2;
        src = 64'hFFFF_FFFF_8000_0000;
        @(negedge clk);
        check(res_r == 64'h0, "R10 held in reset", {bad_r, res_r}, 65'h0);
        rst_n = 1'b1;

        // R2: arithmetic fill with bit 31
        apply(64'hFFFF_FFFF_8000_0000, 5'd4, 64'h0, 2'b01, "R2");
        // R3: logical fill zeros, result sign bit clear
        apply(64'hFFFF_FFFF_8000_0000, 5'd4, 64'h0, 2'b00, "R3");
        // R5: immediate forms ignore count register
        apply(64'h0000_0000_7654_3210, 5'd8, 64'h0000_0000_0000_001F, 2'b00, "R5");
        // R4: register count uses low five bits only
        apply(64'hFFFF_FFFF_F000_00F0, 5'd0, 64'hFFFF_FFFF_FFFF_FFE3, 2'b11, "R4");
        apply(64'h0000_0000_1234_5678, 5'd31, 64'h8000_0000_0000_0040, 2'b10, "R4");
        // R8: zero amount passes word, sign-extended even for logical
        apply(64'hFFFF_FFFF_8765_4321, 5'd0, 64'h0, 2'b00, "R8");
        apply(64'h0000_0000_0765_4321, 5'd0, 64'h0, 2'b01, "R8");
        // R6: logical shift by 31 of negative word
        apply(64'hFFFF_FFFF_FFFF_FFFF, 5'd31, 64'h0, 2'b00, "R6");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 5'd31, 64'h0, 2'b01, "R6");
        // R1, R7, R9: malformed upper bits do not change the shifted value
        apply(64'h1234_5678_0000_F000, 5'd4, 64'h0, 2'b01, "R1");
        apply(64'h0000_0000_8000_0010, 5'd1, 64'h0, 2'b00, "R7");
        apply(64'h0000_0001_0000_0000, 5'd0, 64'h0, 2'b00, "R7");
        apply(64'hAAAA_5555_C000_0003, 5'd2, 64'h2, 2'b11, "R9");

        // full sweep of amounts and operation codes
        for (int o = 0; o < 4; o++) begin
            for (int n = 0; n < 32; n++) begin
                apply(64'hFFFF_FFFF_9ABC_DEF1, 5'(n), {59'h7FF_FFFF_FFFF_FFF, 5'(31 - n)},
                      2'(o), o[0] ? "R2" : "R3");
            end
        end

        repeat (3) @(posedge clk);
        check(ready_q.size() == 0 && pend_q.size() == 0, "R10 drain",
              65'(ready_q.size()), 65'h0);
        finish_run();
    end

endmodule